// File: doc/BRIEF.md
# Buffered Auto-Reload Timer Time-Base

This block is the time-base of a general-purpose timer. A 16-bit counter advances on ticks from a programmable clock divider. It runs between zero and a period limit in one of three ways: it counts up and wraps to zero, it counts down and reloads from the limit, or it moves up and down between the two ends. Each time the counter passes an end it raises an update event. Software can also request an update event, and a disable bit can hold back the events that the hardware raises.

Software reaches the block through a small register port. Writes take effect on a clock edge and reads are combinational. The period and divider values that software writes go into buffer registers, and the counter logic works from shadow copies of them. The divider shadow is loaded only at an update event. The period shadow is loaded either at once on each write or only at an update event, as a preload bit selects. The block drives the live counter value and a one-cycle update pulse, and it keeps a sticky event flag that software can read.

Top module: `tbase_timer`

## Requirements
- R1: After reset the counter is 0, update_o is 0, the timer is stopped, and every register at addresses 0 to 5 reads 0.
- R2: The counter moves only while the run bit (address 0, bit 0) is 1. The enable is delayed by one clock, so with a divider of 0 the first change appears on the second rising edge after the edge that writes run to 1. Once run has been cleared and the delayed enable has dropped, the counter holds its value.
- R3: A divider value D (address 4) advances the counter once every D+1 enabled clocks. A newly written D takes effect only at the next update event. Until then the old divide ratio stays in use.
- R4: Mode 0 (address 0, bits 2:1 = 0) counts up. On a tick at or above the period shadow value A, the counter goes to 0 and an overflow is raised.
- R5: Mode 1 counts down. On a tick at 0, the counter reloads with the period value and an underflow is raised.
- R6: Mode 2 counts 0 up to A and then back down to 0, repeating. An event is raised on the tick that leaves A and on the tick that leaves 0. The very first tick after a forced update is not such a tick. With A = 0 every tick raises an event.
- R7: An update event produces update_o high in the cycle after the edge at which the event occurs. It also sets the sticky flag (address 2, bit 0).
- R8: While the update-disable bit (address 0, bit 3) is 1, the counter still wraps, but a wrap raises no update pulse and loads no shadow register.
- R9: Writing 1 to bit 0 of address 1 forces an update event whatever the disable bit holds. It restarts the divider, loads both shadows, and sets the counter to 0, or to the new period value in mode 1.
- R10: With the preload bit (address 0, bit 4) at 0, a write to the period register (address 5) reaches the shadow on the same edge.
- R11: With the preload bit at 1, a period write changes only the buffer. Reads of address 5 return the buffer value. The counter keeps using the old period until the next update event.
- R12: Writing 0 to bit 0 of address 2 clears the sticky flag. Writing 1 to it leaves the flag as it was.
- R13: A write to address 3 loads the counter on that edge, even while it runs and ahead of any tick in the same cycle. Address 3 reads back the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 event generate, 2 status, 3 count, 4 divider, 5 period) |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| count_o | output | CNT_W | Live counter value |
| update_o | output | 1 | One-cycle update event pulse |

## Verification
Every result has a fixed latency. A register write is visible on count_o and in reads right after its own edge. A tick moves count_o on the edge at which the tick happens, and update_o follows the event edge by one register. With a divider D, the counter's first move comes D+2 edges after the edge that sets run. The bench drives inputs on falling edges and samples each falling edge after the write edge. From the number of elapsed edges k it works out the number of ticks as (k-1)/(D+1), and from that the expected count and pulse for each mode. For the buffered values, the bench watches the peak count between two update pulses rather than a single cycle, because that peak is the period the counter is using.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_CENTER = 2'd2,
    CM_SPARE  = 2'd3
  } cmode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_EVGEN  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_STAT   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_DIV    = 3'd4;
  localparam logic [ADDR_W-1:0] RA_PERIOD = 3'd5;

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     cnt_val,
  input  logic              uev,
  output logic              run,
  output cmode_e            mode,
  output logic              udis,
  output logic              preload,
  output logic [DW-1:0]     arr_sh,
  output logic [DW-1:0]     arr_sh_d,
  output logic [PW-1:0]     div_sh,
  output logic              sw_force,
  output logic              cnt_wr,
  output logic              flag
);

  logic [DW-1:0] arr_buf;
  logic [PW-1:0] div_buf;
  logic          per_wr;

  assign per_wr   = we && (addr == RA_PERIOD);
  assign sw_force = we && (addr == RA_EVGEN) && wdata[0];
  assign cnt_wr   = we && (addr == RA_COUNT);

  // value the period shadow takes at the coming edge
  assign arr_sh_d = (per_wr && !preload) ? wdata : (uev ? arr_buf : arr_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      mode    <= CM_UP;
      udis    <= 1'b0;
      preload <= 1'b0;
      arr_buf <= '0;
      div_buf <= '0;
    end else if (we) begin
      case (addr)
        RA_CTRL: begin
          run     <= wdata[0];
          mode    <= cmode_e'(wdata[2:1]);
          udis    <= wdata[3];
          preload <= wdata[4];
        end
        RA_PERIOD: arr_buf <= wdata;
        RA_DIV:    div_buf <= wdata[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_sh <= '0;
      div_sh <= '0;
      flag   <= 1'b0;
    end else begin
      arr_sh <= arr_sh_d;
      if (uev) div_sh <= div_buf;
      if (uev) flag <= 1'b1;
      else if (we && addr == RA_STAT && !wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL:   rdata = DW'({preload, udis, mode, run});
      RA_STAT:   rdata = DW'(flag);
      RA_COUNT:  rdata = cnt_val;
      RA_DIV:    rdata = DW'(div_buf);
      RA_PERIOD: rdata = arr_buf;
      default:   rdata = '0;
    endcase
  end

  // R11: with preload set, only an update event moves the period shadow
  a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !uev) |=> $stable(arr_sh))
    else $error("a_r11_shadow_hold");

  // R10: immediate transfer of a period write
  a_r10_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && !preload) |=> (arr_sh == $past(wdata)))
    else $error("a_r10_immediate");

  // R7: every update event leaves the sticky flag set
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> flag)
    else $error("a_r7_flag_set");

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick
);

  logic [PW-1:0] pcnt;

  assign tick = cnt_en && !restart && (pcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (cnt_en)  pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  // R3: the divider count never passes the active divide value
  a_r3_pcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= div)
    else $error("a_r3_pcnt_bound");

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  cmode_e        mode,
  input  logic [DW-1:0] arr_sh,
  input  logic [DW-1:0] arr_nx,
  input  logic          force_upd,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count,
  output logic          wrap
);

  logic          dn;
  logic [DW:0]   nxt;

  function automatic logic at_end(input logic [DW-1:0] c, input logic [DW-1:0] lim,
                                  input cmode_e m, input logic d);
    if (m == CM_DOWN || (m == CM_CENTER && d)) return (c == '0);
    return (c >= lim);
  endfunction

  // returns {direction, next value}
  function automatic logic [DW:0] step(input logic [DW-1:0] c, input logic [DW-1:0] nx,
                                       input cmode_e m, input logic d, input logic e);
    case (m)
      CM_DOWN: return {1'b1, (e ? nx : c - 1'b1)};
      CM_CENTER: begin
        if (!d) return e ? {1'b1, ((c == '0) ? c : c - 1'b1)} : {1'b0, c + 1'b1};
        return e ? {1'b0, ((nx == '0) ? {DW{1'b0}} : DW'(1))} : {1'b1, c - 1'b1};
      end
      default: return {1'b0, (e ? {DW{1'b0}} : c + 1'b1)};
    endcase
  endfunction

  assign wrap = tick && !load && !force_upd && at_end(count, arr_sh, mode, dn);
  assign nxt  = step(count, arr_nx, mode, dn, wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      dn    <= 1'b0;
    end else if (load) begin
      count <= load_val;
    end else if (force_upd) begin
      count <= (mode == CM_DOWN) ? arr_nx : '0;
      dn    <= (mode == CM_DOWN);
    end else if (tick) begin
      dn    <= nxt[DW];
      count <= nxt[DW-1:0];
    end
  end

  // R4: an up-count tick at the limit returns to zero
  a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !force_upd && mode == CM_UP && count >= arr_sh) |=> (count == '0))
    else $error("a_r4_up_wrap");

  // R5: a down-count tick away from zero steps by one
  a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !force_upd && mode == CM_DOWN && count != '0)
      |=> (count == $past(count) - 1'b1))
    else $error("a_r5_down_step");

  // R13: a software load wins on its edge
  a_r13_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)))
    else $error("a_r13_load");

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count_o,
  output logic             update_o
);

  logic             run, udis, preload, sw_force, cnt_wr, flag;
  cmode_e           mode;
  logic [CNT_W-1:0] arr_sh, arr_sh_d;
  logic [PSC_W-1:0] div_sh;
  logic             cnt_en_q, tick, wrap, uev, update_q;

  // named internal event: hardware wrap that is not blocked, or a forced update
  assign uev = (wrap && !udis) || sw_force;

  tbase_regs #(.DW(CNT_W), .PW(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cnt_val(count_o), .uev(uev), .run(run), .mode(mode),
    .udis(udis), .preload(preload), .arr_sh(arr_sh), .arr_sh_d(arr_sh_d),
    .div_sh(div_sh), .sw_force(sw_force), .cnt_wr(cnt_wr), .flag(flag)
  );

  tbase_prescaler #(.PW(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en_q), .restart(sw_force),
    .div(div_sh), .tick(tick)
  );

  tbase_counter #(.DW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .arr_sh(arr_sh),
    .arr_nx(arr_sh_d), .force_upd(sw_force), .load(cnt_wr), .load_val(reg_wdata),
    .count(count_o), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en_q <= 1'b0;
      update_q <= 1'b0;
    end else begin
      cnt_en_q <= run;
      update_q <= uev;
    end
  end

  assign update_o = update_q;

  // R2: with the delayed enable low, only software moves the counter
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_q && !cnt_wr && !sw_force) |=> $stable(count_o))
    else $error("a_r2_idle");

  // R7: each event gives a pulse one cycle later
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> update_o)
    else $error("a_r7_pulse");

  // R8: a blocked hardware wrap leaves no pulse
  a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && udis && !sw_force) |=> !update_o)
    else $error("a_r8_blocked");

  // R1: flag only set after some event, pulse only after one
  a_r1_flag_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> update_o)
    else $error("a_r1_flag_origin");

endmodule

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata, count;
  logic        upd;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbase_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .count_o(count), .update_o(upd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  function automatic logic [15:0] ctl(input bit r, input int m, input bit ud, input bit pre);
    return {11'd0, pre, ud, m[1:0], r};
  endfunction

  function automatic int exp_cnt(input int m, input int a, input int t);
    int p;
    if (m == 0) return t % (a + 1);
    if (m == 1) return a - (t % (a + 1));
    if (a == 0) return 0;
    p = t % (2 * a);
    return (p <= a) ? p : 2 * a - p;
  endfunction

  function automatic bit exp_evt(input int m, input int a, input int t);
    if (t < 1) return 1'b0;
    if (m != 2) return (t % (a + 1)) == 0;
    if (a == 0) return 1'b1;
    return (t >= a + 1) && ((t - 1) % a == 0);
  endfunction

  task automatic sweep(input int m, input int a, input int p);
    int n;
    string tag;
    tag = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
    n = 2 * (2 * a + 2) * (p + 1) + 3;
    wr(3'd0, ctl(0, m, 0, 0));
    wr(3'd5, 16'(a));
    wr(3'd4, 16'(p));
    wr(3'd1, 16'd1);
    wr(3'd0, ctl(1, m, 0, 0));
    for (int k = 1; k <= n; k++) begin
      int t;
      bit tk;
      @(negedge clk);
      t  = (k - 1) / (p + 1);
      tk = (k >= 2) && ((k - 1) % (p + 1) == 0);
      if (k == 1) check("R2 first edge after run", int'(count), exp_cnt(m, a, 0));
      else check(tag, int'(count), exp_cnt(m, a, t));
      check("R7 pulse (R3 divide)", int'(upd), int'(tk && exp_evt(m, a, t)));
    end
    wr(3'd0, ctl(0, m, 0, 0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, c0, mx0, mx1, seg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", int'(count), 0);
    check("R1 pulse", int'(upd), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 register", v, 0);
    end
    check("R1 stopped", int'(count), 0);

    // R4 R5 R6 R7 R3 R2 sweeps
    for (int m = 0; m < 3; m++)
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 3; p++)
          sweep(m, a, p);

    // R12 sticky flag
    rd(3'd2, v); check("R7 flag set", v, 1);
    wr(3'd2, 16'd1); rd(3'd2, v); check("R12 write 1 keeps", v, 1);
    wr(3'd2, 16'd0); rd(3'd2, v); check("R12 write 0 clears", v, 0);

    // R8 disable with preload, then R9 forced update
    wr(3'd0, ctl(0, 0, 0, 0)); wr(3'd5, 16'd2); wr(3'd4, 16'd0); wr(3'd1, 16'd1);
    wr(3'd0, ctl(1, 0, 1, 1));
    wr(3'd5, 16'd6);
    mx0 = 0; seg = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (upd) seg++;
      if (int'(count) > mx0) mx0 = int'(count);
    end
    check("R8 no pulse", seg, 0);
    check("R8 shadow kept", mx0, 2);
    rd(3'd5, v); check("R11 buffer read", v, 6);
    wr(3'd1, 16'd1);
    check("R9 force count", int'(count), 0);
    check("R9 force pulse", int'(upd), 1);
    mx0 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'(count) > mx0) mx0 = int'(count);
    end
    check("R9 force loads shadow", mx0, 6);
    wr(3'd0, ctl(1, 1, 1, 1));
    wr(3'd1, 16'd1);
    check("R9 force down", int'(count), 6);
    check("R9 force pulse down", int'(upd), 1);
    wr(3'd0, ctl(0, 0, 0, 0));

    // R11 preload
    wr(3'd0, ctl(0, 0, 0, 1)); wr(3'd5, 16'd5); wr(3'd4, 16'd0); wr(3'd1, 16'd1);
    wr(3'd0, ctl(1, 0, 0, 1));
    wr(3'd5, 16'd2);
    mx0 = 0; mx1 = 0; seg = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd) seg++;
      if (seg == 0 && int'(count) > mx0) mx0 = int'(count);
      if (seg == 1 && int'(count) > mx1) mx1 = int'(count);
    end
    check("R11 old period used", mx0, 5);
    check("R11 new period after update", mx1, 2);
    wr(3'd0, ctl(0, 0, 0, 0));

    // R10 immediate
    wr(3'd5, 16'd5); wr(3'd1, 16'd1);
    wr(3'd0, ctl(1, 0, 0, 0));
    wr(3'd5, 16'd3);
    mx0 = 0; seg = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (upd) seg++;
      if (seg == 0 && int'(count) > mx0) mx0 = int'(count);
    end
    check("R10 immediate period", mx0, 3);
    wr(3'd0, ctl(0, 0, 0, 0));

    // R3 buffered divider
    wr(3'd5, 16'd7); wr(3'd4, 16'd0); wr(3'd1, 16'd1);
    wr(3'd0, ctl(1, 0, 0, 0));
    wr(3'd4, 16'd3);
    c0 = int'(count);
    @(negedge clk);
    check("R3 old divide still active", int'(count), (c0 + 1) % 8);
    seg = 0;
    for (int i = 0; i < 20 && seg == 0; i++) begin
      @(negedge clk);
      if (upd) seg = 1;
    end
    check("R3 update seen", seg, 1);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      check("R3 new divide", int'(count), (j == 4) ? 1 : 0);
    end

    // R13 counter write while running
    wr(3'd3, 16'd5);
    check("R13 load while running", int'(count), 5);

    // R2 stop holds the count
    wr(3'd0, ctl(0, 0, 0, 0));
    @(negedge clk);
    c0 = int'(count);
    repeat (6) @(negedge clk);
    check("R2 stopped holds", int'(count), c0);
    wr(3'd3, 16'd9);
    rd(3'd3, v);
    check("R13 readback", v, 9);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule